// File: doc/BRIEF.md
# Snoop Hit Handler for an Outstanding Miss Entry

This block decides what a coherence snoop does to a miss-tracking entry once the snoop's block address has matched that entry. It first orders the snoop against the entry's own request. The snoop comes first when the entry's request has not been issued yet. It also comes first when the snoop was sent ahead by a lower level that still holds the entry's request unissued. Otherwise the snoop comes second. Which one it is decides whether the entry takes in the snoop.

When the entry takes in the snoop, the block may ask for a copy of the snoop to be stored as a snoop-source target. It may also assert the memory-inhibit, supply-exclusive and shared responses on the snoop. It emits set pulses for the entry's post-invalidate and post-downgrade flags. In both orderings it may ask the target queues to rewrite their upgrade commands. The decision is combinational over the cycle in which `snp_valid` is high. All results are registered on that cycle's rising edge and appear as one-cycle pulses in the next cycle. The target storage and the entry flags live outside the block.

Top module: `snoop_hit_handler`

## Requirements
- R1: When `snp_valid` is high and the snoop comes first (`ent_in_service` low, or `snp_express` and `ent_dstream_pend` both high), the result in the next cycle has `res_absorbed` low and no enqueue, no inhibit, no supply-exclusive, no shared and no flag set pulse.
- R2: A snoop that comes first and has `snp_needs_excl` high pulses both `res_rewrite_act` and `res_rewrite_def`.
- R3: A snoop that comes second pulses `res_rewrite_def` exactly when `snp_needs_excl` is high, and never pulses `res_rewrite_act`.
- R4: A snoop that comes second while `ent_post_inv` is high gives `res_absorbed` high and no enqueue, inhibit, shared or flag set pulse.
- R5: A snoop that comes second, with `ent_post_inv` low and `ent_pend_dirty` high, gives `res_enqueue`, `res_mem_inhibit` and `res_supply_excl` high.
- R6: A snoop that comes second, with `ent_post_inv` low, `ent_pend_dirty` low and `snp_invalidate` high, gives `res_enqueue` high with `res_mem_inhibit` and `res_supply_excl` low. With both `ent_pend_dirty` and `snp_invalidate` low there is no enqueue.
- R7: `res_enq_pending` is high only with `res_enqueue`, and only when `ent_dstream_pend` and `ent_act_needs_excl` were both high.
- R8: `res_set_post_inv` pulses when the snoop is enqueued and `snp_needs_excl` is high.
- R9: A snoop that comes second, with `ent_post_inv` low, `snp_needs_excl` low and `snp_uncacheable` low, pulses `res_set_post_dg` and `res_assert_shared` together, with `res_absorbed` high.
- R10: Results appear exactly one cycle after a `snp_valid` cycle, with `res_valid` high. In every other cycle all result outputs are low.
- R11: While `rst_n` is low at a rising edge, all outputs go low on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | A matching snoop is presented this cycle |
| snp_needs_excl | input | 1 | Snoop requests an exclusive copy |
| snp_invalidate | input | 1 | Snoop invalidates other copies |
| snp_express | input | 1 | Snoop was sent ahead of queued lower-level traffic |
| snp_uncacheable | input | 1 | Snoop is an uncacheable access |
| ent_in_service | input | 1 | Entry's request has been issued |
| ent_dstream_pend | input | 1 | Entry's request is held unissued further down |
| ent_pend_dirty | input | 1 | Entry expects an exclusive (owned) copy |
| ent_post_inv | input | 1 | Entry already has an invalidation queued after its response |
| ent_act_needs_excl | input | 1 | Entry's active target queue needs exclusive access |
| res_valid | output | 1 | Result pulse for the snoop of the previous cycle |
| res_absorbed | output | 1 | Snoop is ordered after the entry's request |
| res_enqueue | output | 1 | Store a copy of the snoop as a snoop-source target |
| res_enq_pending | output | 1 | Stored copy is marked downstream-pending |
| res_mem_inhibit | output | 1 | Assert memory-inhibit on the snoop |
| res_supply_excl | output | 1 | Assert supply-exclusive on the snoop |
| res_assert_shared | output | 1 | Assert shared on the snoop |
| res_set_post_inv | output | 1 | Set the entry's post-invalidate flag |
| res_set_post_dg | output | 1 | Set the entry's post-downgrade flag |
| res_rewrite_act | output | 1 | Rewrite upgrades in the active queue |
| res_rewrite_def | output | 1 | Rewrite upgrades in the deferred queue |

## Verification
The bench drives every combination of the five entry inputs and four snoop inputs while `snp_valid` is high, so each input pattern is tried. Some patterns differ only in the express bit or only in downstream-pending. These show whether the ordering test needs both conditions at once. Others differ only in pending-dirty versus invalidate, and these show the inhibiting enqueue apart from the information-only enqueue. Idle cycles between snoops, and a mid-run reset, check that nothing pulses without a snoop.

// File: rtl/snoop_hit_pkg.sv
// Shared types for the snoop hit handler.
// Assumes: one snoop is presented per valid cycle, already address-matched.
package snoop_hit_pkg;

    // Snoop attributes
    typedef struct packed {
        logic needs_excl;
        logic invalidate;
        logic express;
        logic uncacheable;
    } snp_attr_t;

    // Entry state sampled in the snoop cycle
    typedef struct packed {
        logic in_service;
        logic dstream_pend;
        logic pend_dirty;
        logic post_inv;
        logic act_needs_excl;
    } ent_state_t;

    // Decided actions for one snoop
    typedef struct packed {
        logic absorbed;
        logic enqueue;
        logic enq_pending;
        logic mem_inhibit;
        logic supply_excl;
        logic assert_shared;
        logic set_post_inv;
        logic set_post_dg;
        logic rewrite_act;
        logic rewrite_def;
    } snp_action_t;

    localparam int ACTION_W = $bits(snp_action_t);

endpackage

// File: rtl/snoop_order_cls.sv
// Orders a snoop against the entry's own request.
// Assumes: inputs are valid only in a snoop cycle; output is combinational.
module snoop_order_cls
    import snoop_hit_pkg::*;
(
    input  snp_attr_t  attr,
    input  ent_state_t ent,
    output logic       snoop_first
);
    // The snoop comes first if the entry's request is unissued here, or held unissued below
    always_comb begin
        snoop_first = !ent.in_service || (attr.express && ent.dstream_pend);
    end
endmodule

// File: rtl/snoop_action_dec.sv
// Turns the ordering plus the snoop and entry bits into the action set.
// Assumes: snoop_first comes from snoop_order_cls for the same cycle.
module snoop_action_dec
    import snoop_hit_pkg::*;
(
    input  snp_attr_t   attr,
    input  ent_state_t  ent,
    input  logic        snoop_first,
    output snp_action_t act
);
    logic keep_copy;

    // A copy is kept when ownership is pending or the snoop invalidates
    always_comb begin
        keep_copy = ent.pend_dirty || attr.invalidate;
    end

    // Build the action set for the ordered snoop
    always_comb begin
        act = '0;
        // The deferred queue is re-requested after the snoop in both orderings
        act.rewrite_def = attr.needs_excl;
        if (snoop_first) begin
            act.rewrite_act = attr.needs_excl;
        end else begin
            act.absorbed = 1'b1;
            if (!ent.post_inv) begin
                act.enqueue       = keep_copy;
                act.mem_inhibit   = ent.pend_dirty;
                act.supply_excl   = ent.pend_dirty;
                act.enq_pending   = keep_copy && ent.dstream_pend && ent.act_needs_excl;
                act.set_post_inv  = keep_copy && attr.needs_excl;
                act.set_post_dg   = !attr.needs_excl && !attr.uncacheable;
                act.assert_shared = !attr.needs_excl && !attr.uncacheable;
            end
        end
    end
endmodule

// File: rtl/snoop_result_reg.sv
// Registers the action set into one-cycle result pulses.
// Assumes: synchronous active-low reset; act is meaningful only when valid_in is high.
module snoop_result_reg
    import snoop_hit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_in,
    input  snp_action_t act,
    output logic        valid_q,
    output snp_action_t act_q
);
    // Capture the decision on the snoop cycle's edge; clear it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            act_q   <= '0;
        end else begin
            valid_q <= valid_in;
            act_q   <= valid_in ? act : '0;
        end
    end
endmodule

// File: rtl/snoop_hit_handler.sv
// Top of the snoop hit handler: ordering, action decode, result register.
// Assumes: the caller has matched the snoop to this entry and applies the
// pulses to the entry flags and target queues itself.
module snoop_hit_handler
    import snoop_hit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic snp_valid,
    input  logic snp_needs_excl,
    input  logic snp_invalidate,
    input  logic snp_express,
    input  logic snp_uncacheable,
    input  logic ent_in_service,
    input  logic ent_dstream_pend,
    input  logic ent_pend_dirty,
    input  logic ent_post_inv,
    input  logic ent_act_needs_excl,
    output logic res_valid,
    output logic res_absorbed,
    output logic res_enqueue,
    output logic res_enq_pending,
    output logic res_mem_inhibit,
    output logic res_supply_excl,
    output logic res_assert_shared,
    output logic res_set_post_inv,
    output logic res_set_post_dg,
    output logic res_rewrite_act,
    output logic res_rewrite_def
);
    snp_attr_t   attr;
    ent_state_t  ent;
    logic        snoop_first;
    snp_action_t act;
    snp_action_t act_q;

    // Gather the port bits into the shared structures
    always_comb begin
        attr = '{needs_excl: snp_needs_excl, invalidate: snp_invalidate,
                 express: snp_express, uncacheable: snp_uncacheable};
        ent  = '{in_service: ent_in_service, dstream_pend: ent_dstream_pend,
                 pend_dirty: ent_pend_dirty, post_inv: ent_post_inv,
                 act_needs_excl: ent_act_needs_excl};
    end

    snoop_order_cls u_order (
        .attr        (attr),
        .ent         (ent),
        .snoop_first (snoop_first)
    );

    snoop_action_dec u_dec (
        .attr        (attr),
        .ent         (ent),
        .snoop_first (snoop_first),
        .act         (act)
    );

    snoop_result_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_in (snp_valid),
        .act      (act),
        .valid_q  (res_valid),
        .act_q    (act_q)
    );

    // Drive the result pulses from the registered action set
    always_comb begin
        res_absorbed      = act_q.absorbed;
        res_enqueue       = act_q.enqueue;
        res_enq_pending   = act_q.enq_pending;
        res_mem_inhibit   = act_q.mem_inhibit;
        res_supply_excl   = act_q.supply_excl;
        res_assert_shared = act_q.assert_shared;
        res_set_post_inv  = act_q.set_post_inv;
        res_set_post_dg   = act_q.set_post_dg;
        res_rewrite_act   = act_q.rewrite_act;
        res_rewrite_def   = act_q.rewrite_def;
    end
endmodule

// File: rtl/snoop_hit_handler_chk.sv
// Property checker for snoop_hit_handler, attached by bind.
// Assumes: the same clock and synchronous active-low reset as the top.
module snoop_hit_handler_chk (
    input logic clk,
    input logic rst_n,
    input logic snp_valid,
    input logic snp_needs_excl,
    input logic snp_invalidate,
    input logic snp_express,
    input logic snp_uncacheable,
    input logic ent_in_service,
    input logic ent_dstream_pend,
    input logic ent_pend_dirty,
    input logic ent_post_inv,
    input logic ent_act_needs_excl,
    input logic res_valid,
    input logic res_absorbed,
    input logic res_enqueue,
    input logic res_enq_pending,
    input logic res_mem_inhibit,
    input logic res_supply_excl,
    input logic res_assert_shared,
    input logic res_set_post_inv,
    input logic res_set_post_dg,
    input logic res_rewrite_act,
    input logic res_rewrite_def
);
    AST_UNISSUED_NOT_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && !ent_in_service |=> res_valid && !res_absorbed && !res_enqueue); // R1

    AST_FIRST_BOTH_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && !ent_in_service && snp_needs_excl |=> res_rewrite_act && res_rewrite_def); // R2

    AST_ACTIVE_REWRITE_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        res_rewrite_act |-> !res_absorbed); // R3

    AST_POSTINV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && ent_in_service && !snp_express && ent_post_inv
        |=> res_absorbed && !res_enqueue && !res_set_post_dg); // R4

    AST_INHIBIT_WITH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        res_mem_inhibit |-> res_enqueue && res_supply_excl); // R5

    AST_PENDING_NEEDS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        res_enq_pending |-> res_enqueue); // R7

    AST_POSTINV_NEEDS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        res_set_post_inv |-> res_enqueue && res_rewrite_def); // R8

    AST_SHARED_WITH_DOWNGRADE: assert property (@(posedge clk) disable iff (!rst_n)
        res_assert_shared == res_set_post_dg); // R9

    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !res_valid && !res_absorbed && !res_rewrite_def && !res_rewrite_act); // R10
endmodule

bind snoop_hit_handler snoop_hit_handler_chk u_chk (.*);

// File: tb/snoop_hit_handler_test.sv
`timescale 1ns/1ps
module snoop_hit_handler_test;
    localparam int HALF_NS = 10;
    localparam int LIMIT_CYC = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snp_valid = 0, snp_needs_excl = 0, snp_invalidate = 0, snp_express = 0, snp_uncacheable = 0;
    logic ent_in_service = 0, ent_dstream_pend = 0, ent_pend_dirty = 0, ent_post_inv = 0, ent_act_needs_excl = 0;
    logic res_valid, res_absorbed, res_enqueue, res_enq_pending, res_mem_inhibit, res_supply_excl;
    logic res_assert_shared, res_set_post_inv, res_set_post_dg, res_rewrite_act, res_rewrite_def;

    int checks = 0;
    int failures = 0;
    logic [10:0] exp_q = '0;

    always #HALF_NS clk = ~clk;

    snoop_hit_handler uut (.*);

    // Bit order: valid, absorbed, enqueue, enq_pending, inhibit, supply, shared, post_inv, post_dg, rw_act, rw_def
    function automatic logic [10:0] model(input logic v, ne, inv, ex, unc, ins, dp, pd, pi, ane);
        logic absorbed = 0, enq = 0, pend = 0, inh = 0, sup = 0, shr = 0, spi = 0, sdg = 0, ra = 0, rd = 0;
        if (!v) return '0;
        if (!ins || (ex && dp)) begin
            ra = ne; rd = ne;
        end else begin
            absorbed = 1; rd = ne;
            if (!pi) begin
                if (pd) begin enq = 1; inh = 1; sup = 1; end
                else if (inv) enq = 1;
                if (enq && dp && ane) pend = 1;
                if (enq && ne) spi = 1;
                if (!ne && !unc) begin sdg = 1; shr = 1; end
            end
        end
        return {1'b1, absorbed, enq, pend, inh, sup, shr, spi, sdg, ra, rd};
    endfunction

    function automatic string tag_of(input int b);
        case (b)
            10: return "R10_valid";
            9:  return "R1_absorbed";
            8:  return "R5_R6_enqueue";
            7:  return "R7_enq_pending";
            6:  return "R5_mem_inhibit";
            5:  return "R5_supply_excl";
            4:  return "R9_shared";
            3:  return "R8_post_inv";
            2:  return "R9_post_dg";
            1:  return "R2_rewrite_act";
            default: return "R3_rewrite_def";
        endcase
    endfunction

    // Compare all outputs to the expected vector; tag names the requirement
    task automatic compare(input logic [10:0] exp_v, input string ctx);
        logic [10:0] got;
        got = {res_valid, res_absorbed, res_enqueue, res_enq_pending, res_mem_inhibit, res_supply_excl,
               res_assert_shared, res_set_post_inv, res_set_post_dg, res_rewrite_act, res_rewrite_def};
        for (int b = 0; b < 11; b++) begin
            checks++;
            if (got[b] !== exp_v[b]) begin
                failures++;
                $display("FAIL %s %s: actual=%b expected=%b", ctx, tag_of(b), got[b], exp_v[b]);
            end
        end
    endtask

    task automatic drive(input logic [9:0] p);
        {snp_valid, snp_needs_excl, snp_invalidate, snp_express, snp_uncacheable,
         ent_in_service, ent_dstream_pend, ent_pend_dirty, ent_post_inv, ent_act_needs_excl} = p;
        exp_q = model(p[9], p[8], p[7], p[6], p[5], p[4], p[3], p[2], p[1], p[0]);
    endtask

    // One step: check the previous cycle's result, then present the next inputs
    task automatic step(input logic [9:0] p, input string ctx);
        @(negedge clk);
        compare(exp_q, ctx);
        drive(p);
    endtask

    initial begin
        #(2 * HALF_NS * LIMIT_CYC);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R11: outputs low through reset, even with a snoop presented
        drive('0);
        snp_valid = 1'b1; snp_needs_excl = 1'b1;
        repeat (3) @(negedge clk);
        compare('0, "R11 reset");
        drive('0);
        rst_n = 1'b1;
        // Every snoop/entry combination, back to back (R1..R9)
        for (int i = 0; i < 512; i++) step({1'b1, 9'(i)}, "sweep");
        // Same combinations with idle cycles between them (R10)
        for (int i = 0; i < 512; i++) begin
            step({1'b1, 9'(i)}, "spaced");
            step({1'b0, 9'(i)}, "R10 idle");
        end
        // Mid-run reset clears a pending result (R11)
        step({1'b1, 9'b0_1_0_0_1_0_1_0_0}, "pre-reset");
        rst_n = 1'b0;
        exp_q = '0;
        step('0, "R11 mid-reset");
        rst_n = 1'b1;
        step('0, "R11 after reset");
        step('0, "R10 final");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule